// File: doc/BRIEF.md
# Reconfigurable Add-Compare-Select State Metric Recursion Unit

This block advances the state metrics of a Max-Log-MAP trellis by one time step per clock. A fixed bank of sixteen add-compare-select cells serves three run-time selectable constraint lengths (K = 3, 4 or 5). For each selected K, a routing network picks the two state metrics and two branch labels that feed every cell. The same cells run the recursion in either direction. Forward, each new state takes the better of its two predecessors. Backward, each state takes the better of its two successors.

The four branch metrics come from an upstream unit that has already normalized them. For that reason the recursion holds no metric normalization stage. Instead, every addition saturates at the limits of the signed metric word. A separate strobe seeds the registers. One seeding mode pins the recursion to state zero. The other makes all active states equally likely, which suits a backward pass whose end state is unknown. The surrounding decoder stores the sixteen metric outputs in its window memories and passes them on to likelihood computation.

Top module: `acs_state_metric_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, all sixteen state metrics read 0.
- R2: The constraint-length select uses 0 for K=3 (4 active states), 1 for K=4 (8 active states), and 2 or 3 for K=5 (16 active states). After any seeding or step, every state at or above the active count reads -2048, the most negative metric.
- R3: A seed with the equal-mode bit low loads state 0 with 0 and every other active state with INIT_NEG (default -1024). The load is visible one clock later. A seed takes priority over a step in the same cycle.
- R4: A seed with the equal-mode bit high loads 0 into every active state.
- R5: The trellis uses memory m = K-1. State bit i-1 holds the register stage d_i, where d_1 is the most recent stage. The feedback bit is a = u XOR parity(fb taps on d_1..d_m). The parity bit is p = parity(out taps on a, d_1..d_m). Bit K-1-i of a polynomial is the tap on d_i, with d_0 = a. The feedback/output polynomials are octal 7/5 at K=3, 13/15 at K=4 and 23/35 at K=5. The next state is ((s<<1)|a) masked to m bits. The branch metric for label (u,p) sits in slot 2u+p of the input, 8 bits per slot, signed.
- R6: A forward step sets each active next state to the maximum, over its two predecessor transitions, of the predecessor metric plus the branch metric of that transition.
- R7: A backward step sets each active state to the maximum, over its two input bits, of the successor state's metric plus the branch metric of that transition.
- R8: Each sum saturates to the range -2048..+2047 and never wraps.
- R9: With neither strobe high, all metrics hold regardless of branch metrics, direction or select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ksel_i | input | 2 | Constraint length select |
| bwd_i | input | 1 | 1 = backward recursion, 0 = forward |
| init_i | input | 1 | Seed strobe |
| init_eq_i | input | 1 | Seed mode: 1 = all active states equal |
| step_i | input | 1 | Recursion step strobe |
| bm_i | input | 32 | Four signed branch metrics, slot 2u+p |
| sm_o | output | 192 | Sixteen signed 12-bit state metrics, state j at bits j*12 upward |

## Verification
The recursion is driven with random branch metrics over a dozen steps for each select value in each direction, starting from both seeding modes. A wrong predecessor or successor routing, a swapped branch label or a polynomial error at any single K shows up against an independently enumerated trellis. Constant extreme branch metrics push the metrics into both saturation limits, which separates clamping from wrap-around. A select change from K=5 to K=3 shows whether the upper states are forced. Idle cycles with changing inputs, and a cycle with seed and step raised together, test hold and priority.

// File: rtl/acs_state_metric_unit.sv
module acs_state_metric_unit #(
  parameter int SM_W     = 12,
  parameter int BM_W     = 8,
  parameter int INIT_NEG = -1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             ksel_i,
  input  logic                   bwd_i,
  input  logic                   init_i,
  input  logic                   init_eq_i,
  input  logic                   step_i,
  input  logic [4*BM_W-1:0]      bm_i,
  output logic [16*SM_W-1:0]     sm_o
);
  localparam int MAXM = 4;
  localparam int NS   = 1 << MAXM;
  localparam logic signed [SM_W-1:0] SM_MAX = {1'b0, {(SM_W-1){1'b1}}};
  localparam logic signed [SM_W-1:0] SM_MIN = {1'b1, {(SM_W-1){1'b0}}};

  function automatic logic [4:0] fb_poly(input int m);
    case (m)
      2:       return 5'o7;
      3:       return 5'o13;
      default: return 5'o23;
    endcase
  endfunction

  function automatic logic [4:0] out_poly(input int m);
    case (m)
      2:       return 5'o5;
      3:       return 5'o15;
      default: return 5'o35;
    endcase
  endfunction

  // returns {metric index, u, p} of one of the two edges of cell j
  function automatic logic [5:0] edge_of(input int m, input int j, input logic bwd, input logic b);
    logic [3:0] jj, s, ns, msk;
    logic [4:0] fp, op;
    logic a, u, f, p;
    jj  = 4'(j);
    msk = 4'((1 << m) - 1);
    fp  = fb_poly(m);
    op  = out_poly(m);
    if (!bwd) s = {1'b0, jj[3:1]} | (4'(b) << (m - 1));
    else      s = jj;
    f = 1'b0;
    for (int i = 1; i <= MAXM; i++)
      if (i <= m) f = f ^ (fp[m-i] & s[i-1]);
    if (!bwd) begin
      a = jj[0];
      u = a ^ f;
    end else begin
      u = b;
      a = u ^ f;
    end
    ns = ((s << 1) | {3'b000, a}) & msk;
    p  = op[m] & a;
    for (int i = 1; i <= MAXM; i++)
      if (i <= m) p = p ^ (op[m-i] & s[i-1]);
    return {bwd ? ns : s, u, p};
  endfunction

  function automatic logic signed [SM_W-1:0] sat_add(input logic signed [SM_W-1:0] x,
                                                     input logic signed [BM_W-1:0] y);
    logic signed [SM_W:0] s;
    s = (SM_W+1)'(x) + (SM_W+1)'(y);
    if (s > (SM_W+1)'(SM_MAX))      return SM_MAX;
    else if (s < (SM_W+1)'(SM_MIN)) return SM_MIN;
    else                            return s[SM_W-1:0];
  endfunction

  logic signed [SM_W-1:0] sm_q     [NS];
  logic signed [SM_W-1:0] step_val [NS];
  logic signed [SM_W-1:0] init_val [NS];
  logic signed [BM_W-1:0] bm       [4];
  int m_sel;

  assign m_sel = (ksel_i == 2'd0) ? 2 : (ksel_i == 2'd1) ? 3 : 4;

  for (genvar l = 0; l < 4; l++) begin : g_bm
    assign bm[l] = bm_i[l*BM_W +: BM_W];
  end

  for (genvar j = 0; j < NS; j++) begin : g_cell
    logic [5:0] e0, e1;
    logic signed [SM_W-1:0] c0, c1;
    logic act;
    assign act = j < (1 << m_sel);
    assign e0  = edge_of(m_sel, j, bwd_i, 1'b0);
    assign e1  = edge_of(m_sel, j, bwd_i, 1'b1);
    assign c0  = sat_add(sm_q[e0[5:2]], bm[e0[1:0]]);
    assign c1  = sat_add(sm_q[e1[5:2]], bm[e1[1:0]]);
    assign step_val[j] = !act ? SM_MIN : (c0 > c1) ? c0 : c1;
    assign init_val[j] = !act ? SM_MIN : (init_eq_i || j == 0) ? '0 : SM_W'(INIT_NEG);
    assign sm_o[j*SM_W +: SM_W] = sm_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sm_q <= '{default: '0};
    else if (init_i) sm_q <= init_val;
    else if (step_i) sm_q <= step_val;
  end

  logic low_eq;
  assign low_eq = (sm_q[0] == sm_q[1]) && (sm_q[0] == sm_q[2]) && (sm_q[0] == sm_q[3]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i) |=> $stable(sm_o));

  assert_seed_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && !init_eq_i) |=> (sm_q[0] == '0));

  assert_seed_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && init_eq_i) |=> (sm_q[1] == '0 && sm_q[3] == '0));

  assert_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_i || step_i) && ksel_i == 2'd0) |=> (sm_q[4] == SM_MIN && sm_q[15] == SM_MIN));

  assert_equal_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i && !bwd_i && ksel_i == 2'd0 && bm_i == '0 && low_eq)
      |=> (sm_q[0] == $past(sm_q[0]) && sm_q[3] == $past(sm_q[0])));
endmodule

// File: tb/test_acs_state_metric_unit.sv
`timescale 1ns/1ps
module test_acs_state_metric_unit;
  localparam int SM_W = 12;
  localparam int BM_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ksel = 2'd2;
  logic bwd = 1'b0, init = 1'b0, init_eq = 1'b0, step = 1'b0;
  logic [4*BM_W-1:0] bm = '0;
  logic [16*SM_W-1:0] sm;

  int compared = 0, mismatched = 0;
  int ref_sm[16];
  bit done = 0;

  always #2 clk = ~clk;

  acs_state_metric_unit i_acs_state_metric_unit (
    .clk(clk), .rst_n(rst_n), .ksel_i(ksel), .bwd_i(bwd), .init_i(init),
    .init_eq_i(init_eq), .step_i(step), .bm_i(bm), .sm_o(sm));

  function automatic int clamp(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int mem_of(logic [1:0] k);
    return (k == 2'd0) ? 2 : (k == 2'd1) ? 3 : 4;
  endfunction

  function automatic int bit_at(int poly, int m, int i);
    return (poly >> (m - i)) & 1;
  endfunction

  task automatic model_seed(bit eq);
    int act = 1 << mem_of(ksel);
    for (int s = 0; s < 16; s++)
      ref_sm[s] = (s >= act) ? -2048 : (eq || s == 0) ? 0 : -1024;
  endtask

  task automatic model_step(bit back, int g[4]);
    int m = mem_of(ksel);
    int act = 1 << m;
    int fbp = (m == 2) ? 'o7 : (m == 3) ? 'o13 : 'o23;
    int opp = (m == 2) ? 'o5 : (m == 3) ? 'o15 : 'o35;
    int nw[16];
    for (int s = 0; s < 16; s++) nw[s] = -100000;
    for (int s = 0; s < act; s++)
      for (int u = 0; u < 2; u++) begin
        int f = 0, a, p, ns, c;
        for (int i = 1; i <= m; i++) f ^= bit_at(fbp, m, i) & ((s >> (i-1)) & 1);
        a = u ^ f;
        p = bit_at(opp, m, 0) & a;
        for (int i = 1; i <= m; i++) p ^= bit_at(opp, m, i) & ((s >> (i-1)) & 1);
        ns = ((s << 1) | a) & (act - 1);
        if (!back) begin
          c = clamp(ref_sm[s] + g[2*u+p]);
          if (c > nw[ns]) nw[ns] = c;
        end else begin
          c = clamp(ref_sm[ns] + g[2*u+p]);
          if (c > nw[s]) nw[s] = c;
        end
      end
    for (int s = 0; s < 16; s++) ref_sm[s] = (s >= act) ? -2048 : nw[s];
  endtask

  task automatic check_all(string req);
    for (int j = 0; j < 16; j++) begin
      int got = int'($signed(sm[j*SM_W +: SM_W]));
      compared++;
      if (got !== ref_sm[j]) begin
        mismatched++;
        $display("FAIL %s state %0d: got %0d expected %0d", req, j, got, ref_sm[j]);
      end
    end
  endtask

  task automatic pack_bm(int g[4]);
    for (int l = 0; l < 4; l++) bm[l*BM_W +: BM_W] = 8'(g[l]);
  endtask

  task automatic cycle(bit do_init, bit eq, bit do_step, bit back, int g[4]);
    @(negedge clk);
    init = do_init; init_eq = eq; step = do_step; bwd = back; pack_bm(g);
    @(posedge clk);
    @(negedge clk);
    init = 1'b0; step = 1'b0;
    if (do_init) model_seed(eq);
    else if (do_step) model_step(back, g);
  endtask

  task automatic rand_g(output int g[4]);
    for (int l = 0; l < 4; l++) g[l] = $urandom_range(0, 255) - 128;
  endtask

  task automatic t_reset();
    for (int j = 0; j < 16; j++) ref_sm[j] = 0;
    check_all("R1");
  endtask

  task automatic t_seed_known();
    int z[4] = '{0, 0, 0, 0};
    for (int k = 0; k < 4; k++) begin
      ksel = 2'(k);
      cycle(1, 0, 0, 0, z);
      check_all("R3/R2");
    end
  endtask

  task automatic t_seed_priority();
    int g[4] = '{50, -20, 33, 7};
    ksel = 2'd2;
    cycle(1, 0, 1, 0, g);
    check_all("R3 priority");
  endtask

  task automatic t_forward();
    int g[4];
    for (int k = 0; k < 4; k++) begin
      ksel = 2'(k);
      cycle(1, 0, 0, 0, g);
      for (int n = 0; n < 12; n++) begin
        rand_g(g);
        cycle(0, 0, 1, 0, g);
        check_all("R6/R5");
      end
    end
  endtask

  task automatic t_backward();
    int g[4];
    for (int k = 0; k < 4; k++) begin
      ksel = 2'(k);
      cycle(1, 1, 0, 1, g);
      check_all("R4");
      for (int n = 0; n < 12; n++) begin
        rand_g(g);
        cycle(0, 0, 1, 1, g);
        check_all("R7/R5");
      end
    end
  endtask

  task automatic t_hold();
    int g[4];
    for (int n = 0; n < 6; n++) begin
      rand_g(g);
      ksel = 2'(n % 4);
      cycle(0, 1, 0, n[0], g);
      check_all("R9");
    end
  endtask

  task automatic t_saturation();
    int gp[4] = '{127, 127, 127, 127};
    int gn[4] = '{-128, -128, -128, -128};
    ksel = 2'd0;
    cycle(1, 1, 0, 0, gp);
    for (int n = 0; n < 20; n++) cycle(0, 0, 1, 0, gp);
    check_all("R8 high");
    compared++;
    if (int'($signed(sm[0 +: SM_W])) != 2047) begin
      mismatched++;
      $display("FAIL R8 high clamp: got %0d expected 2047", int'($signed(sm[0 +: SM_W])));
    end
    ksel = 2'd2;
    cycle(1, 0, 0, 0, gn);
    for (int n = 0; n < 20; n++) cycle(0, 0, 1, 1, gn);
    check_all("R8 low");
  endtask

  task automatic t_kswitch();
    int g[4] = '{3, -5, 9, 1};
    ksel = 2'd2;
    cycle(1, 1, 0, 0, g);
    ksel = 2'd0;
    cycle(0, 0, 1, 0, g);
    check_all("R2 switch");
    ksel = 2'd1;
    cycle(0, 0, 1, 1, g);
    check_all("R2 switch K4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seed_known();
    t_seed_priority();
    t_forward();
    t_backward();
    t_hold();
    t_saturation();
    t_kswitch();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule